// File: doc/BRIEF.md
# Reference/PLL Clock Controller with Safe Bypass

This block sits between a phase-locked loop and the rest of a chip's clock tree. Software programs it through a small synchronous register port. A control word powers the loop up or down, holds it in reset or releases it, and picks the reference source. It also disables the loop's output and chooses whether the enable comes from the register or from a pin. Two further registers hold the feedback multiplier and a post-divider ratio with its own enable. Their values go straight out to the analog loop and to the downstream dividers.

The oscillator itself is outside this block. Its output enters on `vco_clk` and is treated as an ideal multiple of the reference. A counter measures the lock time. It starts only while the loop is powered and out of reset, and it restarts the moment either condition is lost. The selected clock leaves on `clk_out` through a two-sided handshake switch. Each side turns its own clock off only while that clock is low. The other side turns on only after the first side has confirmed it is off. Software brings the loop up in this order: keep the bypass, release power-down and reset, wait for lock, then set the enable. The block itself keeps an unlocked clock off `clk_out`.

Top module: `refpll_ctrl`

## Requirements
- R1: After reset, the control word reads 0x0012 (powered down, loop held in reset, output disabled, bypass), the multiplier and post-divider read 0, `locked` is 0, and `clk_out` follows the reference clock.
- R2: A write at address 0 (control), 1 (multiplier) or 2 (post-divider) stores the data masked to the implemented bits. The control mask is 0x033B, the multiplier mask is the low 5 bits, and the post-divider mask is 0x801F (bit 15 = enable, bits 4:0 = ratio). A read pulse loads `rdata` at the next edge. `rdata` holds its value whenever `rd_en` is low.
- R3: `pll_pwrdn` equals control bit 1, `pll_rst_n` equals control bit 3, and `ref_is_osc` equals control bit 8. `pll_mult`, `postdiv_en` and `postdiv_ratio` equal the stored register fields.
- R4: `locked` rises exactly LOCK_CYCLES reference cycles after the edge that stores bit 1 = 0 with bit 3 = 1. It falls one cycle after either condition is lost. Address 3 reads `locked` in bit 0 and zeros elsewhere.
- R5: With the effective enable at 0, `clk_out` carries exactly one pulse per reference cycle.
- R6: With the enable at 1, lock reached, bit 4 = 0 and bit 9 = 0, `clk_out` carries the `vco_clk` pulses.
- R7: An enable set before lock leaves `clk_out` on the reference clock until `locked` rises.
- R8: Control bit 4 = 1 keeps `clk_out` on the reference clock whatever the enable.
- R9: Control bit 5 = 0 takes the enable from control bit 0. Control bit 5 = 1 takes it from the `ext_en` pin and ignores bit 0.
- R10: Control bit 9 = 1 keeps `clk_out` on the reference clock.
- R11: The two clock gates are never open together. After the enable is cleared, `clk_out` is back on the reference clock within 6 reference cycles.
- R12: Writes to address 3 change nothing: a later read of address 3 still returns only the lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also clocks the register port |
| rst_n | input | 1 | Synchronous active-low reset |
| vco_clk | input | 1 | Output of the analog loop |
| ext_en | input | 1 | Enable from a pin, used when control bit 5 is 1 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 control, 1 multiplier, 2 post-divider, 3 status |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered |
| clk_out | output | 1 | Switched clock: reference or loop output |
| pll_pwrdn | output | 1 | Power-down to the analog loop, active high |
| pll_rst_n | output | 1 | Reset to the analog loop, active low |
| ref_is_osc | output | 1 | Reference source select: 1 on-chip oscillator, 0 external input |
| pll_mult | output | 5 | Feedback multiplier value |
| postdiv_en | output | 1 | Post-divider enable |
| postdiv_ratio | output | 5 | Post-divider ratio |
| locked | output | 1 | Lock indication |

## Verification
The assertions check four things on every cycle. The two clock gates are never open together. `locked` clears after power-down or reset. The PLL gate opens only while locked. `rdata` holds its value between read strobes. How the clock switch actually behaves is shown only by the bench scenarios. The bench counts `clk_out` edges over fixed windows while it steps through lock, early enable, output disable, the external-source bit, the pin enable and the return to bypass. A cycle model tracks the registers and the lock counter alongside the design.

// File: rtl/refpll_pkg.sv
`timescale 1ns/1ps
// Package: register addresses, control bit positions and reset/mask constants
// shared by the clock controller modules. Assumes a 16-bit register port.
package refpll_pkg;
    localparam int REG_W = 16;

    typedef enum logic [1:0] {
        RA_CTRL = 2'd0,
        RA_MULT = 2'd1,
        RA_PDIV = 2'd2,
        RA_STAT = 2'd3
    } reg_addr_e;

    localparam int CB_EN     = 0;  // enable: 0 bypass, 1 loop clock
    localparam int CB_PWRDN  = 1;  // loop power-down, active high
    localparam int CB_RSTN   = 3;  // loop reset, active low
    localparam int CB_OUTDIS = 4;  // loop output disable
    localparam int CB_ENSRC  = 5;  // enable source: 0 register, 1 pin
    localparam int CB_REFOSC = 8;  // reference select
    localparam int CB_EXTSRC = 9;  // external source select, keep 0

    localparam logic [REG_W-1:0] CTRL_RESET = 16'h0012;
    localparam logic [REG_W-1:0] CTRL_MASK  = 16'h033B;
    localparam int PDIV_EN_BIT = 15;
endpackage

// File: rtl/refpll_regs.sv
`timescale 1ns/1ps
// Register file: control word, multiplier, post-divider and registered read
// port. Assumes single-cycle strobes in the reference domain.
module refpll_regs
    import refpll_pkg::*;
#(
    parameter int MULT_W = 5,
    parameter int DIV_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             locked,
    output logic [REG_W-1:0] rdata,
    output logic             ctl_en,
    output logic             ctl_pwrdn,
    output logic             ctl_rstn,
    output logic             ctl_outdis,
    output logic             ctl_ensrc,
    output logic             ctl_refosc,
    output logic             ctl_extsrc,
    output logic [MULT_W-1:0] mult,
    output logic             pdiv_en,
    output logic [DIV_W-1:0] pdiv_ratio
);
    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] rd_val;
    reg_addr_e        ra;

    assign ra = reg_addr_e'(addr);

    // Register writes, masked to the implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= CTRL_RESET;
            mult       <= '0;
            pdiv_en    <= 1'b0;
            pdiv_ratio <= '0;
        end else if (wr_en) begin
            case (ra)
                RA_CTRL: ctrl_q <= wdata & CTRL_MASK;
                RA_MULT: mult   <= wdata[MULT_W-1:0];
                RA_PDIV: begin
                    pdiv_en    <= wdata[PDIV_EN_BIT];
                    pdiv_ratio <= wdata[DIV_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_val = '0;
        case (ra)
            RA_CTRL: rd_val = ctrl_q;
            RA_MULT: rd_val[MULT_W-1:0] = mult;
            RA_PDIV: begin
                rd_val[PDIV_EN_BIT] = pdiv_en;
                rd_val[DIV_W-1:0]   = pdiv_ratio;
            end
            default: rd_val[0] = locked;
        endcase
    end

    // Registered read data, held between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_val;
    end

    assign ctl_en     = ctrl_q[CB_EN];
    assign ctl_pwrdn  = ctrl_q[CB_PWRDN];
    assign ctl_rstn   = ctrl_q[CB_RSTN];
    assign ctl_outdis = ctrl_q[CB_OUTDIS];
    assign ctl_ensrc  = ctrl_q[CB_ENSRC];
    assign ctl_refosc = ctrl_q[CB_REFOSC];
    assign ctl_extsrc = ctrl_q[CB_EXTSRC];
endmodule

// File: rtl/refpll_lock.sv
`timescale 1ns/1ps
// Lock timer: counts reference cycles while the loop runs (powered and out
// of reset) and flags lock at LOCK_CYCLES. Any stop clears it next cycle.
module refpll_lock #(
    parameter int LOCK_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic locked
);
    localparam int CW = $clog2(LOCK_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYCLES);

    logic [CW-1:0] cnt_q;

    // Saturating lock counter, restarted whenever the loop stops.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)     cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign locked = (cnt_q == LIMIT);
endmodule

// File: rtl/refpll_clksw.sv
`timescale 1ns/1ps
// Glitch-free two-clock switch. Each side closes its gate only on its own
// falling edge (clock low) and opens only after the other gate is seen
// closed through two flops. Assumes both clocks run while switching.
module refpll_clksw (
    input  logic clk_ref,
    input  logic clk_pll,
    input  logic rst_n,
    input  logic sel_pll,
    output logic ref_gate,
    output logic pll_gate,
    output logic clk_out
);
    logic r_s1;
    logic v_s1;
    logic [1:0] v_rst_q;
    logic v_rstn;

    // Reference side: request flop on the rising edge.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) r_s1 <= 1'b1;
        else        r_s1 <= !sel_pll && !pll_gate;
    end

    // Reference side: gate updated while the reference is low.
    always_ff @(negedge clk_ref) begin
        if (!rst_n) ref_gate <= 1'b1;
        else        ref_gate <= r_s1;
    end

    // Reset brought into the loop-clock domain.
    always_ff @(posedge clk_pll) begin
        v_rst_q <= {v_rst_q[0], rst_n};
    end
    assign v_rstn = v_rst_q[1] && rst_n;

    // Loop side: request flop on the rising edge.
    always_ff @(posedge clk_pll) begin
        if (!v_rstn) v_s1 <= 1'b0;
        else         v_s1 <= sel_pll && !ref_gate;
    end

    // Loop side: gate updated while the loop clock is low.
    always_ff @(negedge clk_pll) begin
        if (!v_rstn) pll_gate <= 1'b0;
        else         pll_gate <= v_s1;
    end

    assign clk_out = (clk_ref && ref_gate) || (clk_pll && pll_gate);
endmodule

// File: rtl/refpll_ctrl.sv
`timescale 1ns/1ps
// Top: PLL controller with safe bypass. Registers drive the analog loop
// pins; the loop clock reaches clk_out only when enabled, locked, not
// disabled and not on the external-source setting.
module refpll_ctrl
    import refpll_pkg::*;
#(
    parameter int MULT_W      = 5,
    parameter int DIV_W       = 5,
    parameter int LOCK_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vco_clk,
    input  logic              ext_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              clk_out,
    output logic              pll_pwrdn,
    output logic              pll_rst_n,
    output logic              ref_is_osc,
    output logic [MULT_W-1:0] pll_mult,
    output logic              postdiv_en,
    output logic [DIV_W-1:0]  postdiv_ratio,
    output logic              locked
);
    logic ctl_en, ctl_outdis, ctl_ensrc, ctl_extsrc;
    logic [1:0] ext_sync_q;
    logic en_eff;
    logic sel_pll;
    logic ref_gate;
    logic pll_gate;

    refpll_regs #(.MULT_W(MULT_W), .DIV_W(DIV_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .locked     (locked),
        .rdata      (rdata),
        .ctl_en     (ctl_en),
        .ctl_pwrdn  (pll_pwrdn),
        .ctl_rstn   (pll_rst_n),
        .ctl_outdis (ctl_outdis),
        .ctl_ensrc  (ctl_ensrc),
        .ctl_refosc (ref_is_osc),
        .ctl_extsrc (ctl_extsrc),
        .mult       (pll_mult),
        .pdiv_en    (postdiv_en),
        .pdiv_ratio (postdiv_ratio)
    );

    refpll_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (!pll_pwrdn && pll_rst_n),
        .locked (locked)
    );

    // Synchronise the pin enable into the reference domain.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sync_q <= 2'b00;
        else        ext_sync_q <= {ext_sync_q[0], ext_en};
    end

    assign en_eff  = ctl_ensrc ? ext_sync_q[1] : ctl_en;
    assign sel_pll = en_eff && locked && !ctl_outdis && !ctl_extsrc;

    refpll_clksw u_sw (
        .clk_ref  (clk),
        .clk_pll  (vco_clk),
        .rst_n    (rst_n),
        .sel_pll  (sel_pll),
        .ref_gate (ref_gate),
        .pll_gate (pll_gate),
        .clk_out  (clk_out)
    );
endmodule

// File: rtl/refpll_ctrl_chk.sv
`timescale 1ns/1ps
// Checker for refpll_ctrl: gate exclusivity, lock behaviour, read hold.
module refpll_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic [15:0] rdata,
    input logic        locked,
    input logic        pll_pwrdn,
    input logic        pll_rst_n,
    input logic        ref_gate,
    input logic        pll_gate
);
    AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_gate && pll_gate)); // R11
    AST_LOCK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_pwrdn || !pll_rst_n) |=> !locked); // R4
    AST_LOCK_RISE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(!pll_pwrdn && pll_rst_n)); // R4
    AST_PLL_GATE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_gate) |-> locked); // R7
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R2
endmodule

bind refpll_ctrl refpll_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rdata     (rdata),
    .locked    (locked),
    .pll_pwrdn (pll_pwrdn),
    .pll_rst_n (pll_rst_n),
    .ref_gate  (ref_gate),
    .pll_gate  (pll_gate)
);

// File: tb/refpll_ctrl_tb.sv
`timescale 1ns/1ps
// Bench: cycle model of registers and lock timer compared on every clock,
// plus edge-count windows on clk_out for the switch behaviour.
module refpll_ctrl_tb;
    localparam int LOCK_N = 64;

    logic clk = 1'b0;
    logic vco_clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_en = 1'b0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic clk_out, pll_pwrdn, pll_rst_n, ref_is_osc, postdiv_en, locked;
    logic [4:0] pll_mult, postdiv_ratio;

    int vecs = 0;
    int fails = 0;
    int edges = 0;

    always #4 clk = ~clk;                      // 125 MHz reference
    initial begin #0.3; forever #1 vco_clk = ~vco_clk; end  // ideal x4 loop

    refpll_ctrl #(.LOCK_CYCLES(LOCK_N)) u_dut (
        .clk(clk), .rst_n(rst_n), .vco_clk(vco_clk), .ext_en(ext_en),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .clk_out(clk_out), .pll_pwrdn(pll_pwrdn),
        .pll_rst_n(pll_rst_n), .ref_is_osc(ref_is_osc), .pll_mult(pll_mult),
        .postdiv_en(postdiv_en), .postdiv_ratio(postdiv_ratio), .locked(locked)
    );

    always @(posedge clk_out) edges = edges + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model.
    logic [15:0] m_ctrl, m_mult, m_pdiv, m_rdata;
    int m_cnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl <= 16'h0012; m_mult <= 0; m_pdiv <= 0; m_rdata <= 0; m_cnt <= 0;
        end else begin
            if (wr_en) begin
                if (addr == 2'd0) m_ctrl <= wdata & 16'h033B;
                if (addr == 2'd1) m_mult <= wdata & 16'h001F;
                if (addr == 2'd2) m_pdiv <= wdata & 16'h801F;
            end
            if (rd_en) begin
                case (addr)
                    2'd0: m_rdata <= m_ctrl;
                    2'd1: m_rdata <= m_mult;
                    2'd2: m_rdata <= m_pdiv;
                    default: m_rdata <= {15'd0, m_cnt == LOCK_N};
                endcase
            end
            if (m_ctrl[1] || !m_ctrl[3]) m_cnt <= 0;
            else if (m_cnt < LOCK_N)     m_cnt <= m_cnt + 1;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 rdata", rdata, m_rdata);
            chk("R4 locked", locked, (m_cnt == LOCK_N));
            chk("R3 pins", {ref_is_osc, pll_rst_n, pll_pwrdn}, {m_ctrl[8], m_ctrl[3], m_ctrl[1]});
            chk("R3 mult/pdiv", {pll_mult, postdiv_en, postdiv_ratio},
                {m_mult[4:0], m_pdiv[15], m_pdiv[4:0]});
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string req, input logic [15:0] exp);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
        chk(req, rdata, exp);
    endtask

    task automatic window(input string req, input int exp);
        int c0;
        repeat (6) @(negedge clk);
        c0 = edges;
        repeat (20) @(negedge clk);
        chk(req, edges - c0, exp);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 locked after reset", locked, 0);
        rd(2'd0, "R1 ctrl reset", 16'h0012);
        rd(2'd1, "R1 mult reset", 16'h0000);
        rd(2'd2, "R1 postdiv reset", 16'h0000);
        window("R1 R5 bypass after reset", 20);

        wr(2'd1, 16'hFFE4);
        rd(2'd1, "R2 mult mask", 16'h0004);
        wr(2'd2, 16'h80E3);
        rd(2'd2, "R2 postdiv mask", 16'h8003);
        wr(2'd0, 16'hFCC9);
        rd(2'd0, "R2 ctrl mask", 16'h0009 | 16'h0000 | (16'hFCC9 & 16'h033B));

        // Enable set before lock: powered, reset released, enabled.
        wr(2'd0, 16'h0009);
        repeat (4) @(negedge clk);
        chk("R7 not yet locked", locked, 0);
        window("R7 early enable stays on reference", 20);
        repeat (LOCK_N) @(negedge clk);
        chk("R4 locked after lock time", locked, 1);
        window("R6 loop clock after lock", 80);
        rd(2'd3, "R4 status lock bit", 16'h0001);

        wr(2'd0, 16'h0019);
        window("R8 output disable forces reference", 20);
        wr(2'd0, 16'h0009);
        window("R6 loop clock restored", 80);
        wr(2'd0, 16'h0209);
        window("R10 external source bit forces reference", 20);
        wr(2'd0, 16'h0009);
        window("R6 loop clock again", 80);

        wr(2'd0, 16'h0008);
        window("R11 back to reference after enable clear", 20);

        wr(2'd0, 16'h0029);
        ext_en = 1'b0;
        window("R9 pin low overrides bit 0", 20);
        ext_en = 1'b1;
        wr(2'd0, 16'h0028);
        window("R9 pin high selects loop", 80);
        ext_en = 1'b0;
        window("R9 pin low returns to reference", 20);

        wr(2'd3, 16'hFFFF);
        rd(2'd3, "R12 status write ignored", 16'h0001);
        rd(2'd0, "R12 ctrl untouched", 16'h0028);

        wr(2'd0, 16'h000A);
        @(negedge clk);
        chk("R4 lock drops on power-down", locked, 0);
        rd(2'd3, "R4 status after power-down", 16'h0000);
        window("R5 bypass after power-down", 20);

        finish_run();
    end
endmodule